// File: doc/BRIEF.md
# Almost-Flag Threshold Unit

This unit keeps the four thresholds that decide when two opposite-direction FIFOs are close to empty or close to full. It turns the fill counts they supply into active-LOW warning flags. For each direction it holds an "empty-side" threshold (X) and a "full-side" threshold (Y). A word count at or below X pulls the almost-empty flag LOW. A number of free locations at or below Y pulls the almost-full flag LOW. The FIFO storage and its pointers live elsewhere. This unit only sees the counts.

The thresholds are set during a master reset strobe. The strobe can load a fixed default into all four registers, or it can arm the unit for a later load. A parallel load takes one threshold per write from the low bits of the port A data bus. A serial load takes one bit per clock on a shared pin pair: the same two pins serve as mode pins during master reset and as serial enable and data afterwards. A partial reset flushes the flags and leaves the thresholds, the chosen method and any load in progress untouched. Everything runs on the port A clock. The fill counts are expected to arrive already in that domain.

Top module: `afo_unit`

## Requirements
- R1: While `rst_n` is LOW, both almost-empty flags read 0 and both almost-full flags read 1. After release, all four thresholds equal 8.
- R2: A clock edge with `mrs_n` LOW and `spm` HIGH loads the same default into all four thresholds. The default is chosen by {`fs1_sen`,`fs0_sd`}: 00 gives 8, 01 gives 16, and 10 or 11 gives 64.
- R3: A clock edge with `mrs_n` LOW and `spm` LOW clears all four thresholds to 0. It selects serial load when `fs0_sd` is 0 and parallel load when `fs0_sd` is 1, whatever `fs1_sen` is.
- R4: In serial mode, each edge with `mrs_n` HIGH and `fs1_sen` LOW shifts `fs0_sd` into the LSB of X2. The four registers form one chain ordered Y1, X1, Y2, X2 from its MSB end, so after 10 bits the first threshold sent sits in X2. After 4×OFS_W bits, sent MSB first, they hold Y1, X1, Y2 and X2.
- R5: In serial mode, bits presented after 4×OFS_W have been taken are ignored, and `fs1_sen` HIGH takes no bit.
- R6: In parallel mode, the first four edges with `par_wr` HIGH load `par_word` into Y1, X1, Y2 and X2 in that order. Later writes are ignored.
- R7: One edge after a count is presented, `ae1_n` (or `ae2_n`) is 0 exactly when `fill1` (or `fill2`) ≤ X1 (or X2).
- R8: One edge after a count is presented, `af1_n` (or `af2_n`) is 0 exactly when 2^OFS_W − `fill1` (or `fill2`) ≤ Y1 (or Y2).
- R9: At each edge with `prs_n` LOW, the flags register the flushed state (almost-empty 0, almost-full 1). Thresholds, load method and load progress are kept.
- R10: At each edge with `mrs_n` LOW, the flags register the flushed state.
- R11: In default mode, `par_wr` and serial bits have no effect on the thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port A clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mrs_n | input | 1 | Master reset strobe, active LOW, sampled on the clock |
| prs_n | input | 1 | Partial reset strobe, active LOW |
| spm | input | 1 | Method select, sampled during master reset |
| fs1_sen | input | 1 | Mode pin during master reset; serial enable (active LOW) afterwards |
| fs0_sd | input | 1 | Mode pin during master reset; serial data afterwards |
| par_wr | input | 1 | Port A write strobe for parallel loading |
| par_word | input | OFS_W | Low bits of the port A data bus |
| fill1 | input | OFS_W+1 | Words stored in FIFO 1 |
| fill2 | input | OFS_W+1 | Words stored in FIFO 2 |
| ae1_n | output | 1 | FIFO 1 almost empty, active LOW |
| af1_n | output | 1 | FIFO 1 almost full, active LOW |
| ae2_n | output | 1 | FIFO 2 almost empty, active LOW |
| af2_n | output | 1 | FIFO 2 almost full, active LOW |

## Verification
A threshold register holding a wrong value shows up only as a flag edge at the wrong count. The bench therefore drives each direction's count to the threshold and one past it on both sides, and every flag is compared one clock later. A wrong serial shift order, or a parallel slot pointer off by one, moves a value into a neighbouring register. That error becomes visible at the first probe after loading, and a probe after only ten serial bits catches a reversed chain direction. A load counter that fails to stop lets a stray bit or write corrupt the registers, and the next probe exposes it.

// File: rtl/afo_pkg.sv
package afo_pkg;

  typedef enum logic [1:0] {
    LD_DEFAULT  = 2'd0,
    LD_SERIAL   = 2'd1,
    LD_PARALLEL = 2'd2
  } ld_mode_e;

  // Method chosen during master reset
  function automatic ld_mode_e pick_mode(input logic spm, input logic fs0);
    if (spm)      return LD_DEFAULT;
    else if (fs0) return LD_PARALLEL;
    else          return LD_SERIAL;
  endfunction

  // Default threshold chosen by the two mode pins
  function automatic int unsigned pick_default(input logic fs1, input logic fs0);
    if (fs1)      return 64;
    else if (fs0) return 16;
    else          return 8;
  endfunction

endpackage

// File: rtl/afo_cfg.sv
module afo_cfg
  import afo_pkg::*;
#(
  parameter int OFS_W = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mrs_n,
  input  logic                 spm,
  input  logic                 fs1_sen,
  input  logic                 fs0_sd,
  input  logic                 par_wr,
  input  logic [OFS_W-1:0]     par_word,
  output logic [4*OFS_W-1:0]   ofs_vec
);

  localparam int SER_BITS = 4 * OFS_W;
  localparam int CNT_W    = $clog2(SER_BITS + 1);
  localparam logic [CNT_W-1:0] SER_LAST = CNT_W'(SER_BITS);
  localparam logic [CNT_W-1:0] PAR_LAST = CNT_W'(4);
  localparam logic [OFS_W-1:0] RST_OFS  = OFS_W'(8);

  ld_mode_e               mode_q, mode_d;
  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic [4*OFS_W-1:0]     ofs_q, ofs_d;

  always_comb begin
    mode_d = mode_q;
    cnt_d  = cnt_q;
    ofs_d  = ofs_q;
    if (!mrs_n) begin
      mode_d = pick_mode(spm, fs0_sd);
      cnt_d  = '0;
      if (spm) ofs_d = {4{OFS_W'(pick_default(fs1_sen, fs0_sd))}};
      else     ofs_d = '0;
    end else begin
      case (mode_q)
        LD_SERIAL: begin
          if (!fs1_sen && (cnt_q != SER_LAST)) begin
            ofs_d = {ofs_q[4*OFS_W-2:0], fs0_sd};
            cnt_d = cnt_q + 1'b1;
          end
        end
        LD_PARALLEL: begin
          if (par_wr && (cnt_q != PAR_LAST)) begin
            for (int s = 0; s < 4; s++) begin
              if (cnt_q == CNT_W'(s)) ofs_d[(3-s)*OFS_W +: OFS_W] = par_word;
            end
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= LD_DEFAULT;
      cnt_q  <= '0;
      ofs_q  <= {4{RST_OFS}};
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
      ofs_q  <= ofs_d;
    end
  end

  assign ofs_vec = ofs_q;

  // R4: a taken serial bit lands in the X2 LSB
  a_r4_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    (mrs_n && mode_q == LD_SERIAL && !fs1_sen && cnt_q != SER_LAST)
      |=> (ofs_q[0] == $past(fs0_sd)));

  // R5: a completed serial load is frozen
  a_r5_serial_done: assert property (@(posedge clk) disable iff (!rst_n)
    (mrs_n && mode_q == LD_SERIAL && cnt_q == SER_LAST) |=> $stable(ofs_q));

  // R6: load progress never runs past its end
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == LD_PARALLEL) |-> (cnt_q <= PAR_LAST));

  // R11: default mode never alters the thresholds
  a_r11_default_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (mrs_n && mode_q == LD_DEFAULT) |=> $stable(ofs_q));

endmodule

// File: rtl/afo_flag.sv
module afo_flag #(
  parameter int OFS_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold,
  input  logic [OFS_W:0]     fill,
  input  logic [OFS_W-1:0]   x_ofs,
  input  logic [OFS_W-1:0]   y_ofs,
  output logic               ae_n,
  output logic               af_n
);

  localparam int CW = OFS_W + 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(1) << OFS_W;

  logic [CW-1:0] room;
  logic          ae_d, af_d, ae_q, af_q;

  always_comb begin
    room = DEPTH_C - fill;
    if (hold) begin
      ae_d = 1'b0;
      af_d = 1'b1;
    end else begin
      ae_d = !(fill <= {1'b0, x_ofs});
      af_d = !(room <= {1'b0, y_ofs});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ae_q <= 1'b0;
      af_q <= 1'b1;
    end else begin
      ae_q <= ae_d;
      af_q <= af_d;
    end
  end

  assign ae_n = ae_q;
  assign af_n = af_q;

  // R9/R10: a reset strobe leaves the flushed flag state
  a_r9_hold_flush: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (!ae_n && af_n));

  // R7: count at or below X asserts almost-empty next cycle
  a_r7_ae_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && fill <= {1'b0, x_ofs}) |=> !ae_n);

  // R8: at most Y free locations asserts almost-full next cycle
  a_r8_af_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && (DEPTH_C - fill) <= {1'b0, y_ofs}) |=> !af_n);

endmodule

// File: rtl/afo_unit.sv
module afo_unit
  import afo_pkg::*;
#(
  parameter int OFS_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mrs_n,
  input  logic             prs_n,
  input  logic             spm,
  input  logic             fs1_sen,
  input  logic             fs0_sd,
  input  logic             par_wr,
  input  logic [OFS_W-1:0] par_word,
  input  logic [OFS_W:0]   fill1,
  input  logic [OFS_W:0]   fill2,
  output logic             ae1_n,
  output logic             af1_n,
  output logic             ae2_n,
  output logic             af2_n
);

  localparam int NDIR = 2;

  logic [4*OFS_W-1:0] ofs_vec;
  logic [OFS_W:0]     fill_arr [NDIR];
  logic [NDIR-1:0]    ae_arr, af_arr;
  logic               hold;

  assign hold        = !mrs_n || !prs_n;
  assign fill_arr[0] = fill1;
  assign fill_arr[1] = fill2;

  afo_cfg #(.OFS_W(OFS_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .mrs_n    (mrs_n),
    .spm      (spm),
    .fs1_sen  (fs1_sen),
    .fs0_sd   (fs0_sd),
    .par_wr   (par_wr),
    .par_word (par_word),
    .ofs_vec  (ofs_vec)
  );

  // Chain layout from MSB: Y1, X1, Y2, X2
  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    afo_flag #(.OFS_W(OFS_W)) u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (hold),
      .fill  (fill_arr[g]),
      .x_ofs (ofs_vec[(2-2*g)*OFS_W +: OFS_W]),
      .y_ofs (ofs_vec[(3-2*g)*OFS_W +: OFS_W]),
      .ae_n  (ae_arr[g]),
      .af_n  (af_arr[g])
    );
  end

  assign ae1_n = ae_arr[0];
  assign af1_n = af_arr[0];
  assign ae2_n = ae_arr[1];
  assign af2_n = af_arr[1];

endmodule

// File: tb/test_afo_unit.sv
module test_afo_unit;
  localparam int W  = 10;
  localparam int D  = 1 << W;
  localparam int CW = W + 1;
  localparam int SB = 4 * W;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, mrs_n, prs_n, spm, fs1_sen, fs0_sd, par_wr;
  logic [W-1:0]  par_word;
  logic [CW-1:0] fill1, fill2;
  logic ae1_n, af1_n, ae2_n, af2_n;

  int errs = 0;
  int checks = 0;
  bit done = 0;
  int my1, mx1, my2, mx2;

  afo_unit #(.OFS_W(W)) i_afo_unit (
    .clk(clk), .rst_n(rst_n), .mrs_n(mrs_n), .prs_n(prs_n), .spm(spm),
    .fs1_sen(fs1_sen), .fs0_sd(fs0_sd), .par_wr(par_wr), .par_word(par_word),
    .fill1(fill1), .fill2(fill2),
    .ae1_n(ae1_n), .af1_n(af1_n), .ae2_n(ae2_n), .af2_n(af2_n)
  );

  function automatic logic exp_ae(int fill, int x);
    return !(fill <= x);
  endfunction

  function automatic logic exp_af(int fill, int y);
    return !((D - fill) <= y);
  endfunction

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic set_all(int v);
    my1 = v; mx1 = v; my2 = v; mx2 = v;
  endtask

  task automatic probe(string req, int f1, int f2);
    fill1 = CW'(f1);
    fill2 = CW'(f2);
    step;
    chk(req, ae1_n, exp_ae(f1, mx1));
    chk(req, af1_n, exp_af(f1, my1));
    chk(req, ae2_n, exp_ae(f2, mx2));
    chk(req, af2_n, exp_af(f2, my2));
  endtask

  task automatic check_all(string req);
    probe(req, mx1, mx2);
    probe(req, mx1 + 1, mx2 + 1);
    probe(req, D - my1, D - my2);
    probe(req, D - my1 - 1, D - my2 - 1);
  endtask

  task automatic chk_flushed(string req);
    chk(req, ae1_n, 1'b0);
    chk(req, af1_n, 1'b1);
    chk(req, ae2_n, 1'b0);
    chk(req, af2_n, 1'b1);
  endtask

  task automatic master(logic s, logic f1, logic f0);
    mrs_n = 1'b0; spm = s; fs1_sen = f1; fs0_sd = f0;
    step;
    chk_flushed("R10");
    mrs_n = 1'b1; fs1_sen = 1'b1; fs0_sd = 1'b0;
    step;
  endtask

  task automatic ser_bits(logic [SB-1:0] v, int hi, int lo);
    for (int i = hi; i >= lo; i--) begin
      fs1_sen = 1'b0;
      fs0_sd  = v[i];
      step;
    end
    fs1_sen = 1'b1;
  endtask

  task automatic par_one(int v);
    par_wr   = 1'b1;
    par_word = W'(v);
    step;
    par_wr   = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [SB-1:0] v;
    int a, b, c, e;
    void'($urandom(32'h1A2B3C4D));
    rst_n = 1'b0; mrs_n = 1'b1; prs_n = 1'b1; spm = 1'b0;
    fs1_sen = 1'b1; fs0_sd = 1'b0; par_wr = 1'b0; par_word = '0;
    fill1 = '0; fill2 = '0;
    step; step;
    chk_flushed("R1");
    rst_n = 1'b1;
    set_all(8);
    check_all("R1");

    // R2 defaults
    master(1'b1, 1'b0, 1'b1); set_all(16); check_all("R2");
    master(1'b1, 1'b1, 1'b0); set_all(64); check_all("R2");
    master(1'b1, 1'b0, 1'b0); set_all(8);  check_all("R2");
    master(1'b1, 1'b1, 1'b1); set_all(64); check_all("R2");

    // R11 default mode ignores loads
    master(1'b1, 1'b0, 1'b1); set_all(16);
    par_one(5); par_one(900);
    v = '0;
    ser_bits(v, 5, 0);
    check_all("R11");

    // R3 / R4 serial
    master(1'b0, 1'b1, 1'b0); set_all(0); check_all("R3");
    a = 'h2A5; b = 'h013; c = 'h3F0; e = 'h1C7;
    v = {W'(a), W'(b), W'(c), W'(e)};
    ser_bits(v, SB-1, SB-W);
    mx2 = a;
    check_all("R4");
    ser_bits(v, SB-W-1, 0);
    my1 = a; mx1 = b; my2 = c; mx2 = e;
    check_all("R4");
    // R5: extra bits ignored
    for (int i = 0; i < 6; i++) begin
      fs1_sen = 1'b0; fs0_sd = 1'($urandom()); step;
    end
    fs1_sen = 1'b1;
    check_all("R5");

    // R3 / R6 / R9 parallel with partial reset mid-load
    master(1'b0, 1'b1, 1'b1); set_all(0); check_all("R3");
    par_one(700); par_one(3);
    my1 = 700; mx1 = 3;
    prs_n = 1'b0; step;
    chk_flushed("R9");
    step;
    chk_flushed("R9");
    prs_n = 1'b1;
    check_all("R9");
    par_one(1000); par_one(64);
    par_one(11);
    my2 = 1000; mx2 = 64;
    check_all("R6");

    // randomized loads and counts
    for (int it = 0; it < 8; it++) begin
      logic pm;
      pm = 1'($urandom());
      master(1'b0, 1'($urandom()), pm);
      a = $urandom_range(D-1, 0); b = $urandom_range(D-1, 0);
      c = $urandom_range(D-1, 0); e = $urandom_range(D-1, 0);
      if (pm) begin
        par_one(a); par_one(b); par_one(c); par_one(e);
      end else begin
        v = {W'(a), W'(b), W'(c), W'(e)};
        ser_bits(v, SB-1, 0);
      end
      my1 = a; mx1 = b; my2 = c; mx2 = e;
      check_all(pm ? "R6" : "R4");
      for (int k = 0; k < 15; k++)
        probe("R7 R8", $urandom_range(D, 0), $urandom_range(D, 0));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule